// File: doc/BRIEF.md
# Base-Bounds Address Translation Unit

This block turns a 32-bit virtual address into a physical address without a TLB. The low half of the address space is the user segment. An address there is checked against a bound and then relocated by a base. There are two base/bound pairs: one for instruction fetches and one for data loads and stores. The upper half of the space belongs to the kernel. Its three segments get a fixed mapping, and the user-segment registers play no part in them. An access in user mode to the upper half is refused.

Each request also receives a 4-bit cacheability attribute. The attribute comes from one of eight 512 MB regions in a region-attribute register, except in the uncached kernel segment, which always yields the uncached code. A refused access raises a fault flag and records its virtual address in a bad-address register.

The unit is configured through a small register write port. A result appears one clock cycle after each request. A two-state machine drives the response valid. ST_IDLE goes to ST_RESP when a request arrives (transition GO). ST_RESP stays in ST_RESP while requests keep arriving (transition NEXT). ST_RESP goes back to ST_IDLE when no request arrives (transition DONE). ST_IDLE stays in ST_IDLE while there are no requests (transition WAIT).

Top module: `bbx_xlate_top`

## Requirements
- R1: After reset, rsp_valid, rsp_fault, rsp_paddr, rsp_cattr and bad_vaddr are all zero. All configuration registers are zero, so every user-segment access faults until a bound is written.
- R2: A request with req_valid high in one cycle produces rsp_valid high in the next cycle, with that request's result. Back-to-back requests give back-to-back results. rsp_valid is low in any cycle that follows a cycle with no request.
- R3: For a fetch (req_kind 0) to an address below 0x80000000 that is strictly less than the instruction bound, rsp_paddr is the address plus the instruction base and rsp_fault is 0. This holds in both user and kernel mode.
- R4: Loads (req_kind 1), stores (req_kind 2) and req_kind 3 use the data base and data bound in place of the instruction pair.
- R5: A user-segment address that is greater than or equal to the selected bound gives rsp_fault 1, rsp_paddr 0 and rsp_cattr 0.
- R6: When a faulting request is captured, bad_vaddr takes that request's virtual address. At all other times it keeps its value.
- R7: In user mode (req_user 1), any address with bit 31 set faults.
- R8: In kernel mode, addresses 0x80000000–0xBFFFFFFF map to the address with bits 31:29 cleared, and addresses 0xC0000000–0xFFFFFFFF pass through unchanged. Neither range ever faults.
- R9: For a non-faulting request, rsp_cattr is bits [4r+3:4r] of the region-attribute register, where r is vaddr[31:29]. The exception is kernel addresses 0xA0000000–0xBFFFFFFF, which give 0 (uncached).
- R10: When cfg_we is high, cfg_sel selects the register written: 0 instruction base, 1 instruction bound, 2 data base, 3 data bound, 4 region attributes. Other select values change nothing. A write affects requests from the next cycle on. A request in the same cycle as a write still sees the old value.
- R11: The relocation add wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 data |
| req_user | input | 1 | 1 user mode, 0 kernel mode |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_cattr | output | 4 | Cacheability attribute (0 on fault) |
| rsp_fault | output | 1 | Address exception |
| bad_vaddr | output | 32 | Last faulting virtual address |

## Verification
Fetches and data accesses are sent to the same offsets against bounds that differ. This shows whether the correct base/bound pair is chosen. Addresses at bound minus one and at the bound itself test the strict less-than compare. A base near the top of the space shows that relocation wraps. Kernel requests in each of the three upper segments, and user requests to the same addresses, separate the fixed mapping, the forced-uncached attribute and the mode-based refusal. A write to an unused select, and a write made in the same cycle as a request, show which configuration value each request actually used.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_DATA  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    localparam logic [2:0] SEG_KCACHED   = 3'b100;
    localparam logic [2:0] SEG_KUNCACHED = 3'b101;

    localparam int SEL_IBASE  = 0;
    localparam int SEL_IBOUND = 1;
    localparam int SEL_DBASE  = 2;
    localparam int SEL_DBOUND = 3;
    localparam int SEL_RATTR  = 4;
endpackage

// File: rtl/bbx_cfg_regs.sv
module bbx_cfg_regs
    import bbx_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SEL_W  = 5,
    parameter int ATTR_W = 4,
    parameter int NREG   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [SEL_W-1:0]       cfg_sel,
    input  logic [AW-1:0]          cfg_wdata,
    output logic [AW-1:0]          ibase,
    output logic [AW-1:0]          ibound,
    output logic [AW-1:0]          dbase,
    output logic [AW-1:0]          dbound,
    output logic [NREG*ATTR_W-1:0] region_attr
);
    localparam int RA_W = NREG * ATTR_W;

    logic hit_ibase, hit_ibound, hit_dbase, hit_dbound, hit_rattr;

    always_comb begin
        hit_ibase  = cfg_we && (cfg_sel == SEL_W'(SEL_IBASE));
        hit_ibound = cfg_we && (cfg_sel == SEL_W'(SEL_IBOUND));
        hit_dbase  = cfg_we && (cfg_sel == SEL_W'(SEL_DBASE));
        hit_dbound = cfg_we && (cfg_sel == SEL_W'(SEL_DBOUND));
        hit_rattr  = cfg_we && (cfg_sel == SEL_W'(SEL_RATTR));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibase       <= '0;
            ibound      <= '0;
            dbase       <= '0;
            dbound      <= '0;
            region_attr <= '0;
        end else begin
            if (hit_ibase)  ibase       <= cfg_wdata;
            if (hit_ibound) ibound      <= cfg_wdata;
            if (hit_dbase)  dbase       <= cfg_wdata;
            if (hit_dbound) dbound      <= cfg_wdata;
            if (hit_rattr)  region_attr <= cfg_wdata[RA_W-1:0];
        end
    end

    // R10: a write to the instruction bound lands in the next cycle
    assert_ibound_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_W'(SEL_IBOUND)) |=> (ibound == $past(cfg_wdata)));

    // R10: an unused select leaves every register untouched
    assert_unused_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel > SEL_W'(SEL_RATTR)) |=>
            ($stable(ibase) && $stable(ibound) && $stable(dbase) &&
             $stable(dbound) && $stable(region_attr)));
endmodule

// File: rtl/bbx_seg_map.sv
module bbx_seg_map
    import bbx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] vaddr,
    input  logic          is_fetch,
    input  logic          user,
    input  logic [AW-1:0] ibase,
    input  logic [AW-1:0] ibound,
    input  logic [AW-1:0] dbase,
    input  logic [AW-1:0] dbound,
    output logic [AW-1:0] paddr,
    output logic          fault,
    output logic          force_uc
);
    logic [2:0]    top3;
    logic [AW-1:0] sel_base, sel_bound;

    always_comb begin
        top3      = vaddr[AW-1 -: 3];
        sel_base  = is_fetch ? ibase  : dbase;
        sel_bound = is_fetch ? ibound : dbound;
        paddr     = '0;
        fault     = 1'b0;
        force_uc  = 1'b0;
        if (!vaddr[AW-1]) begin
            if (vaddr < sel_bound) paddr = vaddr + sel_base;
            else                   fault = 1'b1;
        end else if (user) begin
            fault = 1'b1;
        end else if (top3 == SEG_KCACHED || top3 == SEG_KUNCACHED) begin
            paddr    = {3'b000, vaddr[AW-4:0]};
            force_uc = (top3 == SEG_KUNCACHED);
        end else begin
            paddr = vaddr;
        end
    end
endmodule

// File: rtl/bbx_attr_lookup.sv
module bbx_attr_lookup #(
    parameter int ATTR_W = 4,
    parameter int NREG   = 8,
    localparam int RB    = $clog2(NREG)
) (
    input  logic [NREG*ATTR_W-1:0] region_attr,
    input  logic [RB-1:0]          region,
    input  logic                   force_uc,
    output logic [ATTR_W-1:0]      attr
);
    logic [ATTR_W-1:0] fields [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_field
        assign fields[g] = region_attr[g*ATTR_W +: ATTR_W];
    end

    assign attr = force_uc ? '0 : fields[region];
endmodule

// File: rtl/bbx_xlate_top.sv
module bbx_xlate_top
    import bbx_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SEL_W  = 5,
    parameter int ATTR_W = 4,
    parameter int NREG   = 8,
    localparam int RB    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic [ATTR_W-1:0] rsp_cattr,
    output logic              rsp_fault,
    output logic [AW-1:0]     bad_vaddr
);
    logic [AW-1:0]          ibase, ibound, dbase, dbound;
    logic [NREG*ATTR_W-1:0] region_attr;
    logic [AW-1:0]          map_paddr;
    logic                   map_fault, map_force_uc;
    logic [ATTR_W-1:0]      map_attr;
    rsp_state_e             state_q, state_d;

    bbx_cfg_regs #(.AW(AW), .SEL_W(SEL_W), .ATTR_W(ATTR_W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ibase(ibase), .ibound(ibound), .dbase(dbase),
        .dbound(dbound), .region_attr(region_attr)
    );

    bbx_seg_map #(.AW(AW)) u_map (
        .vaddr(req_vaddr), .is_fetch(req_kind == ACC_FETCH), .user(req_user),
        .ibase(ibase), .ibound(ibound), .dbase(dbase), .dbound(dbound),
        .paddr(map_paddr), .fault(map_fault), .force_uc(map_force_uc)
    );

    bbx_attr_lookup #(.ATTR_W(ATTR_W), .NREG(NREG)) u_attr (
        .region_attr(region_attr), .region(req_vaddr[AW-1 -: RB]),
        .force_uc(map_force_uc), .attr(map_attr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;   // GO
            ST_RESP: if (!req_valid) state_d = ST_IDLE;   // DONE, else NEXT
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rsp_valid = (state_q == ST_RESP);

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr <= '0;
            rsp_cattr <= '0;
            rsp_fault <= 1'b0;
            bad_vaddr <= '0;
        end else if (req_valid) begin
            rsp_fault <= map_fault;
            rsp_paddr <= map_fault ? '0 : map_paddr;
            rsp_cattr <= map_fault ? '0 : map_attr;
            if (map_fault) bad_vaddr <= req_vaddr;
        end
    end

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_resp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_fault_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && rsp_cattr == '0));

    assert_bad_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(bad_vaddr));

    assert_user_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_vaddr[AW-1]) |=>
            (rsp_fault && bad_vaddr == $past(req_vaddr)));

    assert_kseg_cached_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user && req_vaddr[AW-1 -: 3] == SEG_KCACHED) |=>
            (!rsp_fault && rsp_paddr == {3'b000, $past(req_vaddr[AW-4:0])}));

    assert_kseg_uncached_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user && req_vaddr[AW-1 -: 3] == SEG_KUNCACHED) |=>
            (!rsp_fault && rsp_cattr == '0));
endmodule

// File: tb/bbx_xlate_top_tb.sv
`timescale 1ns/1ps
module bbx_xlate_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr, bad_vaddr;
    logic [3:0]  rsp_cattr;

    always #4 clk = ~clk;

    bbx_xlate_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_cattr(rsp_cattr), .rsp_fault(rsp_fault), .bad_vaddr(bad_vaddr)
    );

    typedef struct {
        logic [31:0] paddr;
        logic [3:0]  attr;
        logic        fault;
        logic [31:0] bad;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] sh_ibase = '0, sh_ibound = '0, sh_dbase = '0, sh_dbound = '0;
    logic [31:0] sh_rattr = '0, sh_bad = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind,
                                   input logic user, input string tag);
        exp_t e;
        logic [31:0] base, bound;
        e.tag = tag; e.fault = 1'b0; e.paddr = '0; e.attr = '0;
        base  = (kind == 2'd0) ? sh_ibase  : sh_dbase;
        bound = (kind == 2'd0) ? sh_ibound : sh_dbound;
        if (!va[31]) begin
            if (va < bound) e.paddr = va + base;
            else e.fault = 1'b1;
        end else if (user) begin
            e.fault = 1'b1;
        end else if (va[31:29] == 3'b100 || va[31:29] == 3'b101) begin
            e.paddr = {3'b000, va[28:0]};
        end else begin
            e.paddr = va;
        end
        if (!e.fault && va[31:29] != 3'b101 || !e.fault && user)
            e.attr = 4'((sh_rattr >> (4 * va[31:29])) & 32'hF);
        if (e.fault) sh_bad = va;
        e.bad = sh_bad;
        return e;
    endfunction

    // driver: one request, pushed into the scoreboard
    task automatic send(input logic [31:0] va, input logic [1:0] kind,
                        input logic user, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
        q.push_back(model(va, kind, user, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [4:0] sel, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        case (sel)
            5'd0: sh_ibase = d;
            5'd1: sh_ibound = d;
            5'd2: sh_dbase = d;
            5'd3: sh_dbound = d;
            5'd4: sh_rattr = d;
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // monitor: compares each result against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", "unexpected rsp_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_fault == e.fault, e.tag, "fault", {31'd0, rsp_fault}, {31'd0, e.fault});
                chk(rsp_paddr == e.paddr, e.tag, "paddr", rsp_paddr, e.paddr);
                chk(rsp_cattr == e.attr, e.tag, "cattr", {28'd0, rsp_cattr}, {28'd0, e.attr});
                chk(bad_vaddr == e.bad, {e.tag, "/R6"}, "bad_vaddr", bad_vaddr, e.bad);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(rsp_fault == 1'b0 && rsp_paddr == 0 && rsp_cattr == 0, "R1", "outputs",
            rsp_paddr, 32'd0);
        chk(bad_vaddr == 32'd0, "R1", "bad_vaddr", bad_vaddr, 32'd0);
        send(32'h0000_0010, 2'd0, 1'b1, "R1_zero_bound");
        idle();

        cfg_write(5'd0, 32'h1000_0000);
        cfg_write(5'd1, 32'h0001_0000);
        cfg_write(5'd2, 32'h2000_0000);
        cfg_write(5'd3, 32'h0000_8000);
        cfg_write(5'd4, 32'h8421_5A32);

        // R3 / R4 / R5, back-to-back (R2)
        send(32'h0000_1234, 2'd0, 1'b1, "R3_fetch");
        send(32'h0000_FFFF, 2'd0, 1'b1, "R3_bound_minus1");
        send(32'h0001_0000, 2'd0, 1'b1, "R5_fetch_at_bound");
        send(32'h0000_4000, 2'd1, 1'b1, "R4_load");
        send(32'h0000_7FFF, 2'd2, 1'b1, "R4_store_in");
        send(32'h0000_8000, 2'd2, 1'b1, "R5_store_at_bound");
        send(32'h0000_8000, 2'd0, 1'b1, "R4_fetch_same_offset");
        send(32'h0000_0040, 2'd3, 1'b1, "R4_kind3");
        send(32'h2000_0000, 2'd1, 1'b0, "R5_kernel_useg_oob");
        send(32'h0000_0100, 2'd0, 1'b0, "R3_kernel_useg");
        idle();
        idle();
        chk(rsp_valid == 1'b0, "R2", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // R7 user refusal, R8/R9 kernel segments
        send(32'h8000_0000, 2'd1, 1'b1, "R7_user_kseg0");
        send(32'hC000_0010, 2'd0, 1'b1, "R7_user_kseg2");
        send(32'hA000_0004, 2'd2, 1'b1, "R7_user_kseg1");
        send(32'h8000_1000, 2'd1, 1'b0, "R8_kseg0");
        send(32'hA000_2000, 2'd1, 1'b0, "R9_kseg1_uncached");
        send(32'hBFFF_FFFC, 2'd0, 1'b0, "R8_kseg1_top");
        send(32'hFFFF_FFF0, 2'd1, 1'b0, "R8_kseg2_pass");
        send(32'hC000_0000, 2'd0, 1'b0, "R9_kseg2_region6");
        idle();

        // R11 wrap
        cfg_write(5'd2, 32'hFFFF_F000);
        cfg_write(5'd3, 32'h0001_0000);
        send(32'h0000_2000, 2'd1, 1'b1, "R11_wrap");
        idle();

        // R10 unused select ignored
        cfg_write(5'd9, 32'hFFFF_FFFF);
        cfg_write(5'd31, 32'h0000_0000);
        send(32'h0000_2000, 2'd1, 1'b1, "R10_unused_sel");
        send(32'h0000_1234, 2'd0, 1'b1, "R10_unused_sel_fetch");
        idle();

        // R10 write in the same cycle as a request sees old value
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_0020; req_kind = 2'd0; req_user = 1'b1;
        q.push_back(model(32'h0000_0020, 2'd0, 1'b1, "R10_same_cycle_old"));
        cfg_we = 1'b1; cfg_sel = 5'd0; cfg_wdata = 32'h0300_0000;
        sh_ibase = 32'h0300_0000;
        send(32'h0000_0020, 2'd0, 1'b1, "R10_next_cycle_new");
        cfg_we = 1'b0;
        cfg_write(5'd4, 32'h0000_0000);
        send(32'h0000_0020, 2'd0, 1'b1, "R9_attr_cleared");
        idle();

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule